// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block turns three switchable logic domains off and back on when software asks for it. Each domain has three controls: a power-switch enable, an isolation clamp and a domain reset. A fourth domain is always powered and has no controls here. Software reaches the block through a 32-bit word-addressed register port. A single shared request word carries the power-down and power-up request bits of every domain. Each domain also has its own window of four registers: a gating enable, two delay registers and a status word.

Each request runs through two timed phases. The phase lengths are counted in bus clock cycles and taken from two 6-bit counts in the delay register for that direction. On the way down, the block clamps the outputs first and then opens the switch. On the way up, it closes the switch first, then releases the clamp, and only then releases the domain reset. A power-up request bit stays set while its sequence runs and clears itself when the domain is back on. The status word reports when a domain is fully off.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset every domain is on (switch enable 1, isolation 0, domain reset 0). Every delay register reads 0x0000_0101. The gating enables, the request word and the status words read 0.
- R2: Registers are 32-bit words at byte addresses that are multiples of 4. The request word sits at 0x000. Domain windows start at 0x200, 0x240 and 0x260 (domain outputs 0, 1 and 2). Inside a window: +0x0 is the gating enable in bit 0, +0x4 holds the power-up counts, +0x8 holds the power-down counts, and +0xC is the status word. In a delay register the first-phase count is bits 5:0 and the second-phase count is bits 13:8; all other bits read 0. Any other address reads 0 and ignores writes.
- R3: Domains 0, 1 and 2 use request positions 6, 4 and 0. For position n, bit n requests power-down and bit n+1 requests power-up. Writing 1 sets a request; writing 0 has no effect.
- R4: A power-down request on a domain whose gating enable is 0 is dropped. Its bit clears and the domain stays on.
- R5: Power-down: one cycle after the request is registered, isolation and reset assert. After max(first count,1) cycles the switch opens. After max(second count,1) more cycles, status bit 0 reads 1. The status bit is 1 only while the domain is fully off.
- R6: Power-up: one cycle after the request is registered, the switch closes. After max(first count,1) cycles isolation releases while reset is still held. After max(second count,1) more cycles reset releases.
- R7: The power-up bit reads 1 for the whole power-up sequence and clears in the cycle the domain is back on. On a domain that is already on, it clears one cycle after being set. A power-down bit clears when its request is accepted or dropped.
- R8: When power-down and power-up are both pending at a decision point, including when both are written together, power-up wins and the power-down request is discarded.
- R9: A request registered while a sequence is running is held and acted on once that sequence ends.
- R10: A delay count of 0 behaves like 1: the phase lasts one cycle.
- R11: Domains sequence independently. A request for one domain never changes another domain's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all delays count this clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| sw_on_o | output | 3 | Power-switch enable per domain, 1 = powered |
| iso_o | output | 3 | Isolation clamp per domain, 1 = clamped |
| dom_rst_o | output | 3 | Domain reset per domain, 1 = held in reset |

## Verification
The hardest case is a request that lands while a domain is part-way through the opposite sequence. It has to stay pending through every remaining phase, and the domain must then turn around right after it reaches its end state. The stimulus uses long power-down counts and writes the power-up bit a few cycles after the power-down has started. It then measures the gap between the switch opening and closing again. A second hard case is the same-cycle write of both request bits, which is run on a domain that is off and on one that is on. A cycle-accurate behavioural model checks every output and the read data on every clock.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int NUM_DOM    = 3;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int DLY_W      = 6;
  localparam int DLY_HI_LSB = 8;

  localparam logic [ADDR_W-1:0] DOM_BASE [NUM_DOM] = '{12'h200, 12'h240, 12'h260};
  localparam int                DOM_POS  [NUM_DOM] = '{6, 4, 0};

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_PUP  = 2'd1;
  localparam logic [1:0] OFS_PDN  = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  localparam logic [DLY_W-1:0] DLY_RST = DLY_W'(1);

  typedef enum logic [2:0] {
    PH_ON, PH_DN_ISO, PH_DN_SW, PH_OFF, PH_UP_SW, PH_UP_ISO
  } phase_e;

  typedef struct packed {
    logic [DLY_W-1:0] trail;
    logic [DLY_W-1:0] lead;
  } dly_pair_t;

  function automatic logic [DATA_W-1:0] pack_dly(dly_pair_t p);
    logic [DATA_W-1:0] r;
    r = '0;
    r[DLY_W-1:0]              = p.lead;
    r[DLY_HI_LSB +: DLY_W]    = p.trail;
    return r;
  endfunction
endpackage

// File: rtl/pgc_req_bank.sv
module pgc_req_bank
  import pgc_pkg::*;
#(
  parameter int N  = NUM_DOM,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  pdn_clr_i,
  input  logic [N-1:0]  pup_clr_i,
  output logic [N-1:0]  pdn_req_o,
  output logic [N-1:0]  pup_req_o,
  output logic [DW-1:0] rdata_o
);
  logic [N-1:0] pdn_q, pup_q;

  for (genvar d = 0; d < N; d++) begin : g_req
    localparam int P = DOM_POS[d];
    logic set_up, set_dn;
    // both bits in one write: power-up only
    assign set_up = wr_i & wdata_i[P+1];
    assign set_dn = wr_i & wdata_i[P] & ~wdata_i[P+1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pdn_q[d] <= 1'b0;
        pup_q[d] <= 1'b0;
      end else begin
        pdn_q[d] <= (pdn_q[d] & ~pdn_clr_i[d]) | set_dn;
        pup_q[d] <= (pup_q[d] & ~pup_clr_i[d]) | set_up;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int d = 0; d < N; d++) begin
      rdata_o[DOM_POS[d]]   = pdn_q[d];
      rdata_o[DOM_POS[d]+1] = pup_q[d];
    end
  end

  assign pdn_req_o = pdn_q;
  assign pup_req_o = pup_q;
endmodule

// File: rtl/pgc_dom_regs.sv
module pgc_dom_regs
  import pgc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    offs_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          off_i,
  output logic          gate_en_o,
  output dly_pair_t     pup_o,
  output dly_pair_t     pdn_o,
  output logic [DW-1:0] rdata_o
);
  logic      gate_q;
  dly_pair_t pup_q, pdn_q;
  dly_pair_t wr_pair;

  assign wr_pair.lead  = wdata_i[DLY_W-1:0];
  assign wr_pair.trail = wdata_i[DLY_HI_LSB +: DLY_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      pup_q  <= '{trail: DLY_RST, lead: DLY_RST};
      pdn_q  <= '{trail: DLY_RST, lead: DLY_RST};
    end else if (wr_i) begin
      unique case (offs_i)
        OFS_CTRL: gate_q <= wdata_i[0];
        OFS_PUP:  pup_q  <= wr_pair;
        OFS_PDN:  pdn_q  <= wr_pair;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (offs_i)
      OFS_CTRL: rdata_o[0] = gate_q;
      OFS_PUP:  rdata_o    = pack_dly(pup_q);
      OFS_PDN:  rdata_o    = pack_dly(pdn_q);
      OFS_STAT: rdata_o[0] = off_i;
      default:  ;
    endcase
  end

  assign gate_en_o = gate_q;
  assign pup_o     = pup_q;
  assign pdn_o     = pdn_q;
endmodule

// File: rtl/pgc_dom_seq.sv
module pgc_dom_seq
  import pgc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pdn_req_i,
  input  logic      pup_req_i,
  input  logic      gate_en_i,
  input  dly_pair_t pup_i,
  input  dly_pair_t pdn_i,
  output logic      pdn_clr_o,
  output logic      pup_clr_o,
  output logic      sw_on_o,
  output logic      iso_o,
  output logic      rst_o,
  output logic      off_o
);
  phase_e           st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             ld;
  logic [DLY_W-1:0] ld_val;
  logic             done;

  // count 0 and 1 both finish after one cycle
  assign done = (cnt_q <= DLY_W'(1));

  always_comb begin
    st_d      = st_q;
    ld        = 1'b0;
    ld_val    = '0;
    pdn_clr_o = 1'b0;
    pup_clr_o = 1'b0;
    unique case (st_q)
      PH_ON: begin
        if (pup_req_i) begin
          pup_clr_o = 1'b1;
          pdn_clr_o = pdn_req_i;
        end else if (pdn_req_i) begin
          pdn_clr_o = 1'b1;
          if (gate_en_i) begin
            st_d   = PH_DN_ISO;
            ld     = 1'b1;
            ld_val = pdn_i.lead;
          end
        end
      end
      PH_OFF: begin
        if (pup_req_i) begin
          pdn_clr_o = pdn_req_i;
          st_d      = PH_UP_SW;
          ld        = 1'b1;
          ld_val    = pup_i.lead;
        end else if (pdn_req_i) begin
          pdn_clr_o = 1'b1;
        end
      end
      PH_DN_ISO: if (done) begin
        st_d   = PH_DN_SW;
        ld     = 1'b1;
        ld_val = pdn_i.trail;
      end
      PH_DN_SW: if (done) st_d = PH_OFF;
      PH_UP_SW: if (done) begin
        st_d   = PH_UP_ISO;
        ld     = 1'b1;
        ld_val = pup_i.trail;
      end
      PH_UP_ISO: if (done) begin
        st_d      = PH_ON;
        pup_clr_o = 1'b1;
      end
      default: st_d = PH_ON;
    endcase
  end

  always_comb begin
    if (ld)        cnt_d = ld_val;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q - DLY_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_ON;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    sw_on_o = (st_q == PH_ON) || (st_q == PH_DN_ISO) ||
              (st_q == PH_UP_SW) || (st_q == PH_UP_ISO);
    iso_o   = (st_q != PH_ON) && (st_q != PH_UP_ISO);
    rst_o   = (st_q != PH_ON);
    off_o   = (st_q == PH_OFF);
  end
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgc_pkg::*;
#(
  parameter int N  = NUM_DOM,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic [N-1:0]  sw_on_o,
  output logic [N-1:0]  iso_o,
  output logic [N-1:0]  dom_rst_o
);
  localparam int WIN_LSB = 4;

  logic          aligned, cntr_sel, wr;
  logic [N-1:0]  dom_sel;
  logic [N-1:0]  pdn_req, pup_req, pdn_clr, pup_clr, dom_off;
  logic [DW-1:0] cntr_rd;
  logic [DW-1:0] dom_rd [N];

  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign wr       = bus_req_i & bus_we_i;
  assign cntr_sel = aligned && (bus_addr_i[AW-1:2] == '0);

  pgc_req_bank #(.N(N), .DW(DW)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr & cntr_sel),
    .wdata_i   (bus_wdata_i),
    .pdn_clr_i (pdn_clr),
    .pup_clr_i (pup_clr),
    .pdn_req_o (pdn_req),
    .pup_req_o (pup_req),
    .rdata_o   (cntr_rd)
  );

  for (genvar d = 0; d < N; d++) begin : g_dom
    logic      gate_en;
    dly_pair_t pup_dly, pdn_dly;

    assign dom_sel[d] = aligned &&
      (bus_addr_i[AW-1:WIN_LSB] == DOM_BASE[d][AW-1:WIN_LSB]);

    pgc_dom_regs #(.DW(DW)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr & dom_sel[d]),
      .offs_i    (bus_addr_i[3:2]),
      .wdata_i   (bus_wdata_i),
      .off_i     (dom_off[d]),
      .gate_en_o (gate_en),
      .pup_o     (pup_dly),
      .pdn_o     (pdn_dly),
      .rdata_o   (dom_rd[d])
    );

    pgc_dom_seq u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pdn_req_i (pdn_req[d]),
      .pup_req_i (pup_req[d]),
      .gate_en_i (gate_en),
      .pup_i     (pup_dly),
      .pdn_i     (pdn_dly),
      .pdn_clr_o (pdn_clr[d]),
      .pup_clr_o (pup_clr[d]),
      .sw_on_o   (sw_on_o[d]),
      .iso_o     (iso_o[d]),
      .rst_o     (dom_rst_o[d]),
      .off_o     (dom_off[d])
    );
  end

  always_comb begin
    bus_rdata_o = cntr_sel ? cntr_rd : '0;
    for (int d = 0; d < N; d++)
      if (dom_sel[d]) bus_rdata_o = bus_rdata_o | dom_rd[d];
  end
endmodule

// File: rtl/pwr_gate_seq_chk.sv
module pwr_gate_seq_chk #(
  parameter int N = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] sw_on_i,
  input logic [N-1:0] iso_i,
  input logic [N-1:0] dom_rst_i
);
  always @(posedge clk_i)
    if (!rst_ni)
      assert_reset_on_R1: assert (sw_on_i == '1 && iso_i == '0 && dom_rst_i == '0);

  for (genvar d = 0; d < N; d++) begin : g_chk
    assert_clamped_while_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sw_on_i[d] |-> (iso_i[d] && dom_rst_i[d]));
    assert_iso_before_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sw_on_i[d]) |-> $past(iso_i[d]));
    assert_iso_rise_powered_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(iso_i[d]) |-> (sw_on_i[d] && dom_rst_i[d]));
    assert_release_after_close_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(iso_i[d]) |-> (sw_on_i[d] && $past(sw_on_i[d]) && dom_rst_i[d]));
    assert_reset_after_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dom_rst_i[d]) |-> (!iso_i[d] && !$past(iso_i[d])));
  end
endmodule

bind pwr_gate_seq pwr_gate_seq_chk #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_on_i   (sw_on_o),
  .iso_i     (iso_o),
  .dom_rst_i (dom_rst_o)
);

// File: tb/pwr_gate_seq_bench.sv
module pwr_gate_seq_bench;
  localparam int N = 3;
  localparam int P_ON = 0, P_DA = 1, P_DB = 2, P_OFF = 3, P_UA = 4, P_UB = 5;
  localparam int POS [N]  = '{6, 4, 0};
  localparam int BASE [N] = '{'h200, 'h240, 'h260};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] sw_on, iso, drst;

  int checks = 0, fails = 0, cyc = 0;

  pwr_gate_seq u_pwr_gate_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sw_on_o(sw_on), .iso_o(iso), .dom_rst_o(drst)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  int m_ph [N], m_rem [N], m_ua [N], m_ub [N], m_da [N], m_db [N];
  bit m_pdn [N], m_pup [N], m_gate [N];

  function automatic int len(int c); return (c == 0) ? 1 : c; endfunction

  task automatic model_reset();
    for (int d = 0; d < N; d++) begin
      m_ph[d] = P_ON; m_rem[d] = 0; m_pdn[d] = 0; m_pup[d] = 0; m_gate[d] = 0;
      m_ua[d] = 1; m_ub[d] = 1; m_da[d] = 1; m_db[d] = 1;
    end
  endtask

  task automatic model_step();
    for (int d = 0; d < N; d++) begin
      bit cu = 0, cd = 0, su, sd, wc;
      if (m_ph[d] == P_ON) begin
        if (m_pup[d]) begin cu = 1; cd = m_pdn[d]; end
        else if (m_pdn[d]) begin
          cd = 1;
          if (m_gate[d]) begin m_ph[d] = P_DA; m_rem[d] = len(m_da[d]); end
        end
      end else if (m_ph[d] == P_OFF) begin
        if (m_pup[d]) begin cd = m_pdn[d]; m_ph[d] = P_UA; m_rem[d] = len(m_ua[d]); end
        else if (m_pdn[d]) cd = 1;
      end else if (m_rem[d] > 1) begin
        m_rem[d]--;
      end else begin
        case (m_ph[d])
          P_DA: begin m_ph[d] = P_DB; m_rem[d] = len(m_db[d]); end
          P_DB: m_ph[d] = P_OFF;
          P_UA: begin m_ph[d] = P_UB; m_rem[d] = len(m_ub[d]); end
          default: begin m_ph[d] = P_ON; cu = 1; end
        endcase
      end
      wc = req && we && addr == 12'h000;
      su = wc && wdata[POS[d]+1];
      sd = wc && wdata[POS[d]] && !wdata[POS[d]+1];
      m_pup[d] = (m_pup[d] && !cu) || su;
      m_pdn[d] = (m_pdn[d] && !cd) || sd;
      if (req && we && addr[11:4] == BASE[d][11:4] && addr[1:0] == 0)
        case (addr[3:2])
          2'd0: m_gate[d] = wdata[0];
          2'd1: begin m_ua[d] = wdata[5:0]; m_ub[d] = wdata[13:8]; end
          2'd2: begin m_da[d] = wdata[5:0]; m_db[d] = wdata[13:8]; end
          default: ;
        endcase
    end
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h000)
      for (int d = 0; d < N; d++) begin r[POS[d]] = m_pdn[d]; r[POS[d]+1] = m_pup[d]; end
    for (int d = 0; d < N; d++)
      if (a[11:4] == BASE[d][11:4] && a[1:0] == 0)
        case (a[3:2])
          2'd0: r[0] = m_gate[d];
          2'd1: r = 32'(m_ua[d]) | (32'(m_ub[d]) << 8);
          2'd2: r = 32'(m_da[d]) | (32'(m_db[d]) << 8);
          default: r[0] = (m_ph[d] == P_OFF);
        endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) model_reset();
    else model_step();

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // clock-by-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    logic [N-1:0] e_sw, e_iso, e_rst;
    for (int d = 0; d < N; d++) begin
      e_sw[d]  = m_ph[d] inside {P_ON, P_DA, P_UA, P_UB};
      e_iso[d] = !(m_ph[d] inside {P_ON, P_UB});
      e_rst[d] = m_ph[d] != P_ON;
    end
    chk(32'(sw_on), 32'(e_sw), "R5/R11 switch enables");
    chk(32'(iso), 32'(e_iso), "R5/R11 isolation");
    chk(32'(drst), 32'(e_rst), "R6 domain reset");
    chk(rdata, m_read(addr), "R2/R7 read data");
  end

  // edge timestamps per domain
  int t_iso_up [N], t_iso_dn [N], t_sw_up [N], t_sw_dn [N], t_rst_dn [N];
  logic [N-1:0] p_sw = '1, p_iso = '0, p_rst = '0;
  always @(negedge clk) begin
    for (int d = 0; d < N; d++) begin
      if (iso[d] && !p_iso[d]) t_iso_up[d] = cyc;
      if (!iso[d] && p_iso[d]) t_iso_dn[d] = cyc;
      if (sw_on[d] && !p_sw[d]) t_sw_up[d] = cyc;
      if (!sw_on[d] && p_sw[d]) t_sw_dn[d] = cyc;
      if (!drst[d] && p_rst[d]) t_rst_dn[d] = cyc;
    end
    p_sw = sw_on; p_iso = iso; p_rst = drst;
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, output int t);
    @(posedge clk); #1;
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    t = cyc; req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(rdata, exp, tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish (R1..R11 incomplete)");
    summary();
    $finish;
  end

  initial begin
    int t, t2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(32'(sw_on), 32'h7, "R1 switch after reset");
    chk(32'(iso | drst), 0, "R1 iso/reset after reset");
    rd(12'h204, 32'h101, "R1 up delays reset");
    rd(12'h248, 32'h101, "R1 down delays reset");
    rd(12'h260, 0, "R1 gate enable reset");
    rd(12'h26C, 0, "R1 status reset");
    rd(12'h000, 0, "R1 request word reset");

    // R2 map: unmapped access and field widths
    wr(12'h100, 32'hFFFF_FFFF, t);
    rd(12'h100, 0, "R2 unmapped read");
    wr(12'h264, 32'hFFFF_FFFF, t);
    rd(12'h264, 32'h3F3F, "R2 delay field width");
    wr(12'h264, 32'h101, t);

    // R4: gating disabled, request dropped
    wr(12'h000, 32'h40, t);
    idle(4);
    rd(12'h000, 0, "R4 dropped request bit");
    chk(32'(iso), 0, "R4 domain stays on");

    // R5: domain 0 down, counts 3 and 2
    wr(12'h200, 32'h1, t);
    wr(12'h208, 32'h0203, t);
    wr(12'h000, 32'h40, t);
    idle(10);
    chk(t_iso_up[0] - t, 1, "R5 isolation one cycle after request");
    chk(t_sw_dn[0] - t_iso_up[0], 3, "R5 first down phase");
    rd(12'h20C, 1, "R5 status off");
    chk(32'(sw_on), 32'h6, "R11 others untouched");

    // R6/R7: domain 0 up, counts 2 and 4
    wr(12'h204, 32'h0402, t);
    wr(12'h000, 32'h80, t);
    rd(12'h000, 32'h80, "R7 up bit held while running");
    idle(10);
    chk(t_sw_up[0] - t, 1, "R6 switch closes one cycle after request");
    chk(t_iso_dn[0] - t_sw_up[0], 2, "R6 isolation release delay");
    chk(t_rst_dn[0] - t_iso_dn[0], 4, "R6 reset release delay");
    rd(12'h000, 0, "R7 up bit self-clears");
    rd(12'h20C, 0, "R5 status back on");

    // R10: zero counts on domain 1
    wr(12'h240, 32'h1, t);
    wr(12'h248, 32'h0, t);
    wr(12'h000, 32'h10, t);
    idle(6);
    chk(t_sw_dn[1] - t_iso_up[1], 1, "R10 zero count lasts one cycle");
    rd(12'h24C, 1, "R10 domain off");

    // R8: both bits on an off domain -> powers up, down dropped
    wr(12'h000, 32'h30, t);
    idle(8);
    rd(12'h24C, 0, "R8 up wins on off domain");
    rd(12'h000, 0, "R8 down discarded");
    chk(32'(iso), 0, "R8 stays on");

    // R8/R7: both bits on an on domain
    wr(12'h260, 32'h1, t);
    wr(12'h000, 32'h03, t);
    idle(4);
    chk(32'(sw_on), 32'h7, "R8 on domain untouched");
    rd(12'h000, 0, "R7 up bit clears on on domain");

    // R9: up request during a long down sequence on domain 2
    wr(12'h268, 32'h0505, t);
    wr(12'h000, 32'h01, t);
    idle(2);
    wr(12'h000, 32'h02, t2);
    rd(12'h000, 32'h02, "R9 up held during down");
    idle(20);
    chk(t_sw_up[2] - t_sw_dn[2], 6, "R9 up starts after down ends");
    rd(12'h26C, 0, "R9 domain back on");

    // R11/R3: two domains together
    wr(12'h000, 32'h50, t);
    idle(12);
    chk(32'(sw_on), 32'h4, "R3 R11 both down, domain 2 on");
    wr(12'h000, 32'hA0, t);
    wr(12'h000, 32'h00, t2);
    idle(20);
    chk(32'(sw_on), 32'h7, "R3 zero write no effect, all on");

    summary();
    $finish;
  end
endmodule